// File: doc/BRIEF.md
# Codec Link Reset and Wake Controller

This block manages the reset and link state inside a codec that talks to its controller over a serial link made of a bit clock, a frame sync line and two serial data lines. The block runs entirely from a local free-running oscillator. That clock keeps ticking when the link bit clock is stopped, so the block can time events while the link is down. It distinguishes three ways of returning to a known state:
- a cold reset from the asynchronous active-low reset pin, which clears everything;
- a warm reset, which is a long high pulse on the sync line while the link is powered down, restarts the link and keeps register contents;
- a register reset, which is a write of any value to register address zero and returns only the registers to their defaults.

A power-down request stops the bit clock and serial data output cleanly at a frame boundary. While the link is down, an external wake event is passed straight through to the serial data input line as a wake request to the controller. After a warm reset is recognised, the bit clock stays off until the sync line has been seen low again. This keeps the link from mistaking the tail of the warm-reset pulse for the start of a frame. A parameter selects secondary-codec operation, in which the bit clock pad is never driven.

Top module: `codec_link_rstctl`

## Requirements
- R1: While `rst_pin_n` is low, the block is in reset at once, without waiting for a clock edge. In that state `regs_rst` is 1, `bclk_run`, `sdo_en`, `bclk_oe` and `regs_clr` are 0, and `link_status` is 2'b00.
- R2: Reset is released synchronously. After `rst_pin_n` rises, `regs_rst` falls and `bclk_run` and `sdo_en` rise on the second oscillator edge, not on the first. `link_status` is 2'b00 (running) after release.
- R3: In the powered-down state (`link_status` 2'b01), the sync line is sampled through a two-flop synchronizer. If it is seen high for WARM_CNT consecutive oscillator edges, `link_status` becomes 2'b10 (waiting for sync low). WARM_CNT is OSC_MHZ*WARM_NS/1000 rounded up, which is 1 µs by default. A high stretch one edge shorter leaves the state at 2'b01.
- R4: While `link_status` is 2'b10, `bclk_run` and `sdo_en` stay low. Once the synchronized sync line is low, the state returns to 2'b00 and the link restarts. This happens on the third edge after the pin falls.
- R5: The warm-reset timer clears whenever the synchronized sync line is low. Two high stretches of WARM_CNT-1 edges each, separated by one low cycle, do not trigger a warm reset.
- R6: While the link is running, a write (`reg_wr` high) with `reg_addr` equal to zero makes `regs_clr` high for exactly one cycle, on the edge after the write. `regs_rst`, `bclk_run` and `link_status` are not disturbed.
- R7: A write to any nonzero address, or any write while `link_status` is not 2'b00, produces no `regs_clr` pulse.
- R8: In the running state, `pd_req` and `frame_end` sampled high on the same edge move the state to 2'b01 and turn off `bclk_run` and `sdo_en` on that edge. `pd_req` without `frame_end` has no effect.
- R9: `sdi_wake` follows `wake_evt` combinationally only while `link_status` is 2'b01. At all other times it is 0.
- R10: With SECONDARY=1, `bclk_oe` is never asserted. With SECONDARY=0, `bclk_oe` equals `bclk_run`.
- R11: A warm reset raises neither `regs_rst` nor `regs_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local free-running oscillator clock |
| rst_pin_n | input | 1 | Asynchronous active-low cold reset pin |
| sync_pin | input | 1 | Frame sync line from the controller (asynchronous while the link is down) |
| reg_wr | input | 1 | Control register write strobe, in the oscillator domain |
| reg_addr | input | AW | Control register write address |
| pd_req | input | 1 | Link power-down request |
| frame_end | input | 1 | Pulse marking the last cycle of a frame |
| wake_evt | input | 1 | External event requesting wake-up |
| bclk_run | output | 1 | Enable for the bit clock gate |
| bclk_oe | output | 1 | Output enable for the bit clock pad |
| sdo_en | output | 1 | Enable for the serial data output |
| regs_rst | output | 1 | Register file reset, held for a cold reset |
| regs_clr | output | 1 | One-cycle register-default strobe |
| sdi_wake | output | 1 | Drives the serial data input line high as a wake request |
| link_status | output | 2 | 00 running, 01 powered down, 10 waiting for sync low |

## Verification
The properties assume that `reg_wr`, `reg_addr`, `pd_req` and `frame_end` are already synchronous to the oscillator. They also assume that `sync_pin` and `rst_pin_n` may change at any time, because they pass through synchronizers. The register-reset property also assumes that a write strobe is a single cycle, so that every `regs_clr` pulse can be traced to exactly one qualifying write. The stimulus changes every input on the falling oscillator edge and keeps write strobes one cycle wide. It times sync pulses in whole oscillator cycles, so the exact warm-reset boundary of WARM_CNT edges can be hit from both sides.

// File: rtl/codec_rst_pkg.sv
package codec_rst_pkg;

   typedef enum logic [1:0] {
      LS_RUN   = 2'b00,
      LS_PDOWN = 2'b01,
      LS_WAIT  = 2'b10
   } link_state_e;

endpackage

// File: rtl/crst_sync_bit.sv
module crst_sync_bit #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("crst_sync_bit: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) ff <= {STAGES{RST_VAL}};
      else         ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];

endmodule

// File: rtl/crst_warm_timer.sv
module crst_warm_timer #(
   parameter int WARM_CNT = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic level,
   output logic hit
);

   localparam int            CW   = $clog2(WARM_CNT + 1);
   localparam logic [CW-1:0] LAST = CW'(WARM_CNT - 1);

   generate
      if (WARM_CNT < 2) begin : g_bad_cnt
         $error("crst_warm_timer: WARM_CNT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   // The count restarts whenever the line drops or the timer is disarmed.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!arm || !level) cnt <= '0;
      else if (cnt != LAST)    cnt <= cnt + 1'b1;
   end

   assign hit = arm && level && (cnt == LAST);

endmodule

// File: rtl/crst_link_fsm.sv
module crst_link_fsm
   import codec_rst_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pd_req,
   input  logic        frame_end,
   input  logic        warm_hit,
   input  logic        sync_lvl,
   output link_state_e state
);

   link_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         LS_RUN:   if (pd_req && frame_end) nxt = LS_PDOWN;
         LS_PDOWN: if (warm_hit)            nxt = LS_WAIT;
         LS_WAIT:  if (!sync_lvl)           nxt = LS_RUN;
         default:                           nxt = LS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= LS_RUN;
      else        state <= nxt;
   end

endmodule

// File: rtl/codec_link_rstctl.sv
module codec_link_rstctl
   import codec_rst_pkg::*;
#(
   parameter int OSC_MHZ     = 24,
   parameter int WARM_NS     = 1000,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 7,
   parameter bit SECONDARY   = 1'b0
) (
   input  logic          osc_clk,
   input  logic          rst_pin_n,
   input  logic          sync_pin,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic          pd_req,
   input  logic          frame_end,
   input  logic          wake_evt,
   output logic          bclk_run,
   output logic          bclk_oe,
   output logic          sdo_en,
   output logic          regs_rst,
   output logic          regs_clr,
   output logic          sdi_wake,
   output logic [1:0]    link_status
);

   localparam int WARM_CNT = (OSC_MHZ * WARM_NS + 999) / 1000;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("codec_link_rstctl: AW must be at least 1");
      end
      if (OSC_MHZ < 1 || WARM_NS < 1) begin : g_bad_time
         $error("codec_link_rstctl: OSC_MHZ and WARM_NS must be positive");
      end
   endgenerate

   logic        rst_n_int;
   logic        sync_s;
   logic        warm_hit;
   logic        link_up;
   link_state_e state;

   // Reset: asserted asynchronously, released through the synchronizer.
   crst_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk    (osc_clk),
      .arst_n (rst_pin_n),
      .d      (1'b1),
      .q      (rst_n_int)
   );

   crst_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sync (
      .clk    (osc_clk),
      .arst_n (rst_pin_n),
      .d      (sync_pin),
      .q      (sync_s)
   );

   crst_warm_timer #(.WARM_CNT(WARM_CNT)) u_warm (
      .clk   (osc_clk),
      .rst_n (rst_n_int),
      .arm   (state == LS_PDOWN),
      .level (sync_s),
      .hit   (warm_hit)
   );

   crst_link_fsm u_fsm (
      .clk       (osc_clk),
      .rst_n     (rst_n_int),
      .pd_req    (pd_req),
      .frame_end (frame_end),
      .warm_hit  (warm_hit),
      .sync_lvl  (sync_s),
      .state     (state)
   );

   always_ff @(posedge osc_clk or negedge rst_n_int) begin
      if (!rst_n_int) regs_clr <= 1'b0;
      else            regs_clr <= reg_wr && (reg_addr == '0) && (state == LS_RUN);
   end

   assign link_up     = rst_n_int && (state == LS_RUN);
   assign bclk_run    = link_up;
   assign sdo_en      = link_up;
   assign regs_rst    = !rst_n_int;
   assign sdi_wake    = wake_evt && rst_n_int && (state == LS_PDOWN);
   assign link_status = state;

   generate
      if (SECONDARY) begin : g_secondary
         assign bclk_oe = 1'b0;
      end else begin : g_primary
         assign bclk_oe = link_up;
      end
   endgenerate

endmodule

// File: rtl/codec_link_rstctl_chk.sv
module codec_link_rstctl_chk
   import codec_rst_pkg::*;
#(
   parameter int AW        = 7,
   parameter bit SECONDARY = 1'b0
) (
   input logic          clk,
   input logic          rst_pin_n,
   input logic          rst_n_int,
   input logic          sync_s,
   input logic          reg_wr,
   input logic [AW-1:0] reg_addr,
   input logic          pd_req,
   input logic          frame_end,
   input logic          bclk_run,
   input logic          bclk_oe,
   input logic          sdo_en,
   input logic          regs_rst,
   input logic          regs_clr,
   input logic          sdi_wake,
   input logic [1:0]    link_status
);

   // R1
   cold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
      regs_rst |-> (!bclk_run && !sdo_en && !regs_clr));

   // R3
   warm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
      (link_status == LS_WAIT && $past(link_status) != LS_WAIT)
         |-> ($past(link_status) == LS_PDOWN && $past(sync_s)));

   // R4
   holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
      (link_status == LS_WAIT) |-> (!bclk_run && !sdo_en));

   // R4
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
      (link_status == LS_RUN && $past(link_status) == LS_WAIT) |-> !$past(sync_s));

   // R6
   clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
      regs_clr |-> ($past(reg_wr) && $past(reg_addr) == '0 && $past(link_status) == LS_RUN));

   // R8
   pdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
      (link_status == LS_PDOWN && $past(link_status) == LS_RUN)
         |-> $past(pd_req && frame_end));

   // R9
   wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
      sdi_wake |-> (link_status == LS_PDOWN));

   generate
      if (SECONDARY) begin : g_sec_chk
         // R10
         sec_pad_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
            !bclk_oe);
      end
   endgenerate

endmodule

bind codec_link_rstctl codec_link_rstctl_chk #(.AW(AW), .SECONDARY(SECONDARY)) u_chk (
   .clk         (osc_clk),
   .rst_pin_n   (rst_pin_n),
   .rst_n_int   (rst_n_int),
   .sync_s      (sync_s),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .pd_req      (pd_req),
   .frame_end   (frame_end),
   .bclk_run    (bclk_run),
   .bclk_oe     (bclk_oe),
   .sdo_en      (sdo_en),
   .regs_rst    (regs_rst),
   .regs_clr    (regs_clr),
   .sdi_wake    (sdi_wake),
   .link_status (link_status)
);

// File: tb/codec_link_rstctl_bench.sv
module codec_link_rstctl_bench;

   localparam int OSC_MHZ = 100;
   localparam int WARM    = OSC_MHZ;   // 1 us at 100 MHz
   localparam int AW      = 7;

   // Warm-reset pulse table: sync high length in cycles, expected status after.
   localparam int NV = 5;
   localparam int       VEC_LEN [NV] = '{WARM - 1, WARM, WARM + 20, 1, 2 * WARM};
   localparam bit [1:0] VEC_EXP [NV] = '{2'b01, 2'b00, 2'b00, 2'b01, 2'b00};

   logic          clk = 1'b0;
   logic          rst_pin_n;
   logic          sync_pin;
   logic          reg_wr;
   logic [AW-1:0] reg_addr;
   logic          pd_req;
   logic          frame_end;
   logic          wake_evt;
   logic          bclk_run, bclk_oe, sdo_en, regs_rst, regs_clr, sdi_wake;
   logic [1:0]    link_status;
   logic          s_bclk_run, s_bclk_oe, s_sdo_en, s_regs_rst, s_regs_clr, s_sdi_wake;
   logic [1:0]    s_link_status;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   codec_link_rstctl #(.OSC_MHZ(OSC_MHZ), .AW(AW), .SECONDARY(1'b0)) u_codec_link_rstctl (
      .osc_clk(clk), .rst_pin_n(rst_pin_n), .sync_pin(sync_pin), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .pd_req(pd_req), .frame_end(frame_end), .wake_evt(wake_evt),
      .bclk_run(bclk_run), .bclk_oe(bclk_oe), .sdo_en(sdo_en), .regs_rst(regs_rst),
      .regs_clr(regs_clr), .sdi_wake(sdi_wake), .link_status(link_status)
   );

   codec_link_rstctl #(.OSC_MHZ(OSC_MHZ), .AW(AW), .SECONDARY(1'b1)) u_sec (
      .osc_clk(clk), .rst_pin_n(rst_pin_n), .sync_pin(sync_pin), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .pd_req(pd_req), .frame_end(frame_end), .wake_evt(wake_evt),
      .bclk_run(s_bclk_run), .bclk_oe(s_bclk_oe), .sdo_en(s_sdo_en), .regs_rst(s_regs_rst),
      .regs_clr(s_regs_clr), .sdi_wake(s_sdi_wake), .link_status(s_link_status)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic go_pdown();
      pd_req = 1'b1; frame_end = 1'b1;
      cyc(1);
      pd_req = 1'b0; frame_end = 1'b0;
   endtask

   task automatic sync_pulse(input int len);
      sync_pin = 1'b1;
      cyc(len);
      sync_pin = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_pin_n = 1'b0; sync_pin = 1'b0; reg_wr = 1'b0; reg_addr = '0;
      pd_req = 1'b0; frame_end = 1'b0; wake_evt = 1'b0;
      cyc(3);
      // R1: reset state
      chk("R1", "regs_rst", int'(regs_rst), 1);
      chk("R1", "bclk_run", int'(bclk_run), 0);
      chk("R1", "sdo_en", int'(sdo_en), 0);
      chk("R1", "link_status", int'(link_status), 0);
      chk("R1", "regs_clr", int'(regs_clr), 0);

      // R2: synchronous release on the second edge
      rst_pin_n = 1'b1;
      cyc(1);
      chk("R2", "regs_rst after 1 edge", int'(regs_rst), 1);
      chk("R2", "bclk_run after 1 edge", int'(bclk_run), 0);
      cyc(1);
      chk("R2", "regs_rst after 2 edges", int'(regs_rst), 0);
      chk("R2", "bclk_run after 2 edges", int'(bclk_run), 1);
      chk("R2", "sdo_en after 2 edges", int'(sdo_en), 1);
      chk("R10", "primary bclk_oe", int'(bclk_oe), 1);
      chk("R10", "secondary bclk_oe", int'(s_bclk_oe), 0);

      // R8: power-down needs a frame boundary
      pd_req = 1'b1;
      cyc(1);
      chk("R8", "status without frame_end", int'(link_status), 0);
      chk("R8", "bclk_run without frame_end", int'(bclk_run), 1);
      frame_end = 1'b1;
      cyc(1);
      pd_req = 1'b0; frame_end = 1'b0;
      chk("R8", "status at boundary", int'(link_status), 1);
      chk("R8", "bclk_run at boundary", int'(bclk_run), 0);
      chk("R8", "sdo_en at boundary", int'(sdo_en), 0);
      chk("R10", "primary bclk_oe down", int'(bclk_oe), 0);

      // R9: wake passes through while down
      wake_evt = 1'b1;
      #1;
      chk("R9", "sdi_wake while down", int'(sdi_wake), 1);
      wake_evt = 1'b0;
      #1;
      chk("R9", "sdi_wake released", int'(sdi_wake), 0);

      // R7: register reset ignored while down
      reg_wr = 1'b1; reg_addr = '0;
      cyc(1);
      reg_wr = 1'b0;
      chk("R7", "regs_clr while down", int'(regs_clr), 0);

      // R3, R11: warm-reset pulse table
      for (int v = 0; v < NV; v++) begin
         if (link_status != 2'b01) go_pdown();
         sync_pulse(VEC_LEN[v]);
         cyc(5);
         chk("R3", $sformatf("status after pulse %0d", VEC_LEN[v]),
             int'(link_status), int'(VEC_EXP[v]));
         chk("R11", "regs_rst after pulse", int'(regs_rst), 0);
      end

      // R5: interrupted stretches do not accumulate
      if (link_status != 2'b01) go_pdown();
      sync_pulse(WARM - 1);
      cyc(1);
      sync_pulse(WARM - 1);
      cyc(5);
      chk("R5", "status after split pulse", int'(link_status), 1);

      // R4: hold-off until sync falls
      sync_pin = 1'b1;
      cyc(WARM + 10);
      chk("R4", "status while sync high", int'(link_status), 2);
      chk("R4", "bclk_run while sync high", int'(bclk_run), 0);
      sync_pin = 1'b0;
      cyc(2);
      chk("R4", "status 2 edges after fall", int'(link_status), 2);
      chk("R4", "sdo_en 2 edges after fall", int'(sdo_en), 0);
      cyc(1);
      chk("R4", "status 3 edges after fall", int'(link_status), 0);
      chk("R4", "bclk_run 3 edges after fall", int'(bclk_run), 1);
      chk("R11", "regs_clr after warm", int'(regs_clr), 0);

      // R6: register reset strobe
      reg_wr = 1'b1; reg_addr = '0;
      cyc(1);
      reg_wr = 1'b0;
      chk("R6", "regs_clr pulse", int'(regs_clr), 1);
      chk("R6", "regs_rst during pulse", int'(regs_rst), 0);
      chk("R6", "bclk_run during pulse", int'(bclk_run), 1);
      cyc(1);
      chk("R6", "regs_clr next cycle", int'(regs_clr), 0);

      // R7: nonzero address
      reg_wr = 1'b1; reg_addr = AW'(5);
      cyc(1);
      reg_wr = 1'b0;
      chk("R7", "regs_clr nonzero addr", int'(regs_clr), 0);

      // R9: no wake while running
      wake_evt = 1'b1;
      #1;
      chk("R9", "sdi_wake while running", int'(sdi_wake), 0);
      wake_evt = 1'b0;

      // R1, R2: cold reset from the powered-down state
      go_pdown();
      rst_pin_n = 1'b0;
      #1;
      chk("R1", "regs_rst immediate", int'(regs_rst), 1);
      chk("R1", "status immediate", int'(link_status), 0);
      chk("R1", "bclk_run immediate", int'(bclk_run), 0);
      cyc(2);
      rst_pin_n = 1'b1;
      cyc(2);
      chk("R2", "bclk_run after cold", int'(bclk_run), 1);
      chk("R2", "status after cold", int'(link_status), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule